// File: doc/BRIEF.md
# Serial Control Word Loader

This block takes 16-bit command words from a three-wire serial link (an active-low frame line, a serial clock and one data line) and turns each word into a register write. The first two bits of a word pick the target: the control register, one of two 28-bit frequency registers, or one of two 12-bit phase registers. The control register sets how frequency words are written. In paired mode, two words in a row to the same frequency register form one atomic 28-bit value. In half mode, a single word replaces either the upper or the lower 14 bits.

Shifting runs on the serial clock. Each finished word crosses into the master-clock domain through a toggle handshake and a two-flop synchronizer. There it becomes a single write pulse into the register file. The register outputs feed an oscillator datapath that lives outside this block.

Top module: `sdds_word_loader`

## Requirements
- R1: Data is taken most significant bit first, one bit on each falling edge of `ser_clk` while `ser_frame_n` is low; sixteen bits make one word.
- R2: While `ser_frame_n` stays low, every further group of 16 falling edges forms another word, and each of those words is applied in arrival order.
- R3: Word bits 15:14 route the write: 00 to the control register, 01 to frequency register 0, 10 to frequency register 1, 11 to a phase register. No register changes except through a decoded write.
- R4: In a phase word, bit 13 picks phase register 0 (0) or 1 (1), bits 11:0 are the new value, and bit 12 has no effect.
- R5: With control bit 13 set (paired mode), the first word to a frequency register supplies its bits 13:0 and the second supplies bits 27:14; the register keeps its old value until the second word arrives, then takes both halves at once.
- R6: With control bit 13 clear (half mode), control bit 12 set writes word bits 13:0 into frequency bits 27:14, and control bit 12 clear writes them into bits 13:0; the other half keeps its value.
- R7: A staged lower half in paired mode is dropped when the next word goes to any other address (control, phase or the other frequency register); a word to a different frequency register then starts a new pair.
- R8: If `ser_frame_n` rises before 16 bits have arrived, those bits are discarded and the next frame starts a fresh word.
- R9: Control word bits 13:0 appear unchanged on `ctl_bits` at the same positions (13 pairing, 12 half select, 11 and 10 register selects, 8 clear, 7 and 6 sleep, 5 bit output, 3 divide, 1 waveform); setting bit 8 does not clear any register in this block.
- R10: After `rst_n` is held low, all register outputs read zero and no frequency half is staged.
- R11: Each word is applied exactly once, and the register outputs show it within 6 `clk` cycles after its 16th falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset; hold it across at least one falling edge of `ser_clk` |
| ser_clk | input | 1 | Serial clock; data is sampled on its falling edge |
| ser_frame_n | input | 1 | Active-low frame; a high level aborts a partial word |
| ser_data | input | 1 | Serial data, MSB first |
| ctl_bits | output | 14 | Control register bits 13:0 |
| freq0_word | output | 28 | Frequency register 0 |
| freq1_word | output | 28 | Frequency register 1 |
| phase0_word | output | 12 | Phase register 0 |
| phase1_word | output | 12 | Phase register 1 |

## Verification
A stale staged half or a wrong pairing flag does not show on the ports right away. It shows on the next frequency word: a register that should hold its value changes, or a completed pair comes out with a wrong lower half. So each word is checked on its own, a few master cycles after it lands. A bit counter that did not reset shows on the next whole word as a wrong destination or a shifted value. A missed or doubled handshake pulse shows within the same six-cycle window as a missing or repeated write.

// File: rtl/sdds_pkg.sv
// Shared constants and types for the serial control word loader.
package sdds_pkg;
    localparam int WORD_W  = 16;
    localparam int FREQ_W  = 28;
    localparam int HALF_W  = FREQ_W / 2;
    localparam int PHASE_W = 12;
    localparam int CTL_W   = WORD_W - 2;

    // control register bit positions that the write path itself uses
    localparam int CB_PAIR = 13;
    localparam int CB_HIGH = 12;

    // destination prefix carried in word bits 15:14
    typedef enum logic [1:0] {
        DST_CTL = 2'b00,
        DST_FR0 = 2'b01,
        DST_FR1 = 2'b10,
        DST_PH  = 2'b11
    } dst_e;
endpackage

// File: rtl/sdds_ser_shift.sv
// Serial front end: shifts bits MSB first on the falling serial clock while
// the frame is low, and hands each complete word over by flipping a toggle.
// Assumes: the frame line clears the bit counter asynchronously, so a short
// frame leaves nothing behind; rst_n spans at least one serial falling edge.
module sdds_ser_shift
    import sdds_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         ser_clk,
    input  logic         ser_frame_n,
    input  logic         ser_data,
    input  logic         rst_n,
    output logic [W-1:0] word_q,
    output logic         tog_q
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [W-2:0]     sh_q;

    // bit counter; an idle frame restarts it at zero (R8)
    always_ff @(negedge ser_clk or posedge ser_frame_n) begin
        if (ser_frame_n) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // shift path, MSB arrives first (R1)
    always_ff @(negedge ser_clk) begin
        if (!ser_frame_n) sh_q <= {sh_q[W-3:0], ser_data};
    end

    // capture the finished word and flip the handover toggle (R1, R2)
    always_ff @(negedge ser_clk) begin
        if (!rst_n) begin
            tog_q  <= 1'b0;
            word_q <= '0;
        end else if (!ser_frame_n && cnt_q == LAST) begin
            word_q <= {sh_q, ser_data};
            tog_q  <= ~tog_q;
        end
    end

    // a sixteenth bit inside a frame always produces a handover
    p_word_tick_r1: assert property (@(negedge ser_clk) disable iff (!rst_n)
        (!ser_frame_n && cnt_q == LAST) |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/sdds_word_sync.sv
// Brings the handover toggle into the master domain and turns each flip into
// one write pulse carrying the captured word.
// Assumes: the captured word stays stable for far longer than the
// synchronizer delay (16 serial periods against a few master cycles).
module sdds_word_sync
    import sdds_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tog_in,
    input  logic [W-1:0] word_in,
    output logic         wr_vld,
    output logic [W-1:0] wr_word
);
    logic [STAGES-1:0] chain_q;
    logic              seen_q;
    logic              flip;

    // synchronizer chain for the toggle
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= tog_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], tog_in};
            end
        end
    endgenerate

    assign flip = chain_q[STAGES-1] ^ seen_q;

    // remember the last toggle level acted on, register the write pulse (R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            wr_vld  <= 1'b0;
            wr_word <= '0;
        end else begin
            seen_q <= chain_q[STAGES-1];
            wr_vld <= flip;
            if (flip) wr_word <= word_in;
        end
    end

    // one word gives one pulse, never two back to back
    p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |=> !wr_vld);
endmodule

// File: rtl/sdds_reg_bank.sv
// Decodes write pulses into the control, frequency and phase registers,
// staging the lower half of a paired frequency load until its partner comes.
// Assumes: at most one write pulse per cycle, words already in clk domain.
module sdds_reg_bank
    import sdds_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int FW  = FREQ_W,
    parameter int PW  = PHASE_W,
    parameter int NREG = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_vld,
    input  logic [W-1:0]           wr_word,
    output logic [W-3:0]           ctl_q,
    output logic [NREG-1:0][FW-1:0] freq_q,
    output logic [NREG-1:0][PW-1:0] phase_q
);
    localparam int HW = FW / 2;

    dst_e           dst;
    logic           is_freq;
    logic           fidx;
    logic           pend_q;
    logic           pidx_q;
    logic [HW-1:0]  lo_q;
    logic           pair_hit;
    logic [NREG-1:0] fr_full, fr_hi, fr_lo;

    assign dst      = dst_e'(wr_word[W-1:W-2]);
    assign is_freq  = (dst == DST_FR0) || (dst == DST_FR1);
    assign fidx     = (dst == DST_FR1);
    assign pair_hit = pend_q && (pidx_q == fidx);

    // per-register write strobes from the pairing mode and half select
    always_comb begin
        fr_full = '0;
        fr_hi   = '0;
        fr_lo   = '0;
        if (wr_vld && is_freq) begin
            if (ctl_q[CB_PAIR]) fr_full[fidx] = pair_hit;
            else if (ctl_q[CB_HIGH]) fr_hi[fidx] = 1'b1;
            else fr_lo[fidx] = 1'b1;
        end
    end

    // control register (R9); its clear bit touches nothing here
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else if (wr_vld && dst == DST_CTL) ctl_q <= wr_word[W-3:0];
    end

    // staging of the lower half and its cancellation (R5, R7)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            pidx_q <= 1'b0;
            lo_q   <= '0;
        end else if (wr_vld) begin
            if (is_freq && ctl_q[CB_PAIR] && !pair_hit) begin
                pend_q <= 1'b1;
                pidx_q <= fidx;
                lo_q   <= wr_word[HW-1:0];
            end else begin
                pend_q <= 1'b0;
            end
        end
    end

    // frequency registers, one per index (R5, R6)
    generate
        for (genvar i = 0; i < NREG; i++) begin : g_freq
            // full commit or single-half update of register i
            always_ff @(posedge clk) begin
                if (!rst_n)          freq_q[i] <= '0;
                else if (fr_full[i]) freq_q[i] <= {wr_word[HW-1:0], lo_q};
                else if (fr_hi[i])   freq_q[i][FW-1:HW] <= wr_word[HW-1:0];
                else if (fr_lo[i])   freq_q[i][HW-1:0]  <= wr_word[HW-1:0];
            end
        end
    endgenerate

    // phase registers, bit 13 selects, bit 12 unused (R4)
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else if (wr_vld && dst == DST_PH) phase_q[wr_word[W-3]] <= wr_word[PW-1:0];
    end

    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vld |=> ($stable(ctl_q) && $stable(freq_q) && $stable(phase_q)));

    p_phase_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && wr_word[W-1:W-2] == 2'b11 && !wr_word[W-3])
            |=> (phase_q[0] == $past(wr_word[PW-1:0])));

    p_first_half_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && is_freq && ctl_q[CB_PAIR] && !pair_hit) |=> $stable(freq_q));

    p_other_half_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && wr_word[W-1:W-2] == 2'b01 && !ctl_q[CB_PAIR] && ctl_q[CB_HIGH])
            |=> (freq_q[0][HW-1:0] == $past(freq_q[0][HW-1:0])));
endmodule

// File: rtl/sdds_word_loader.sv
// Top of the serial control word loader: serial shifter, clock-domain
// handover and register file, with the registers brought out flat.
// Assumes: serial clock period well above the master clock period.
module sdds_word_loader
    import sdds_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_frame_n,
    input  logic               ser_data,
    output logic [CTL_W-1:0]   ctl_bits,
    output logic [FREQ_W-1:0]  freq0_word,
    output logic [FREQ_W-1:0]  freq1_word,
    output logic [PHASE_W-1:0] phase0_word,
    output logic [PHASE_W-1:0] phase1_word
);
    logic [WORD_W-1:0]             cap_word;
    logic                          cap_tog;
    logic                          wr_vld;
    logic [WORD_W-1:0]             wr_word;
    logic [1:0][FREQ_W-1:0]        freq_q;
    logic [1:0][PHASE_W-1:0]       phase_q;

    sdds_ser_shift #(.W(WORD_W)) u_shift (
        .ser_clk     (ser_clk),
        .ser_frame_n (ser_frame_n),
        .ser_data    (ser_data),
        .rst_n       (rst_n),
        .word_q      (cap_word),
        .tog_q       (cap_tog)
    );

    sdds_word_sync #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tog_in  (cap_tog),
        .word_in (cap_word),
        .wr_vld  (wr_vld),
        .wr_word (wr_word)
    );

    sdds_reg_bank #(.W(WORD_W), .FW(FREQ_W), .PW(PHASE_W), .NREG(2)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_vld  (wr_vld),
        .wr_word (wr_word),
        .ctl_q   (ctl_bits),
        .freq_q  (freq_q),
        .phase_q (phase_q)
    );

    assign freq0_word  = freq_q[0];
    assign freq1_word  = freq_q[1];
    assign phase0_word = phase_q[0];
    assign phase1_word = phase_q[1];
endmodule

// File: tb/sim_sdds_word_loader.sv
module sim_sdds_word_loader;
    localparam int CLK_PERIOD = 10;
    localparam int SER_HALF   = 20;
    localparam int SETTLE     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b1;
    logic ser_frame_n = 1'b1;
    logic ser_data = 1'b0;
    logic [13:0] ctl_bits;
    logic [27:0] freq0_word, freq1_word;
    logic [11:0] phase0_word, phase1_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdds_word_loader u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_frame_n(ser_frame_n),
        .ser_data(ser_data), .ctl_bits(ctl_bits), .freq0_word(freq0_word),
        .freq1_word(freq1_word), .phase0_word(phase0_word), .phase1_word(phase1_word)
    );

    // reference state, built from the requirements
    logic [13:0] m_ctl = '0;
    logic [27:0] m_f0 = '0, m_f1 = '0;
    logic [11:0] m_p0 = '0, m_p1 = '0;
    logic        m_pend = 1'b0, m_pidx = 1'b0;
    logic [13:0] m_lo = '0;

    logic [93:0] exp_q[$];
    string       tag_q[$];
    event        chk_ev;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    function automatic void model(input logic [15:0] w);
        logic idx;
        case (w[15:14])
            2'b00: begin m_ctl = w[13:0]; m_pend = 1'b0; end
            2'b11: begin
                if (w[13]) m_p1 = w[11:0]; else m_p0 = w[11:0];
                m_pend = 1'b0;
            end
            default: begin
                idx = w[15];
                if (m_ctl[13]) begin
                    if (m_pend && m_pidx == idx) begin
                        if (idx) m_f1 = {w[13:0], m_lo}; else m_f0 = {w[13:0], m_lo};
                        m_pend = 1'b0;
                    end else begin
                        m_lo = w[13:0]; m_pend = 1'b1; m_pidx = idx;
                    end
                end else begin
                    if (m_ctl[12]) begin
                        if (idx) m_f1[27:14] = w[13:0]; else m_f0[27:14] = w[13:0];
                    end else begin
                        if (idx) m_f1[13:0] = w[13:0]; else m_f0[13:0] = w[13:0];
                    end
                    m_pend = 1'b0;
                end
            end
        endcase
    endfunction

    task automatic push_expect(input string tag);
        exp_q.push_back({m_ctl, m_f0, m_f1, m_p0, m_p1});
        tag_q.push_back(tag);
        ->chk_ev;
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b;
        #(SER_HALF) ser_clk = 1'b0;
        #(SER_HALF) ser_clk = 1'b1;
    endtask

    // one frame carrying n words, then wait and queue the expectation
    task automatic send_frame(input logic [15:0] w [4], input int n, input string tag);
        ser_frame_n = 1'b0;
        #(SER_HALF);
        for (int k = 0; k < n; k++) begin
            for (int b = 15; b >= 0; b--) shift_bit(w[k][b]);
            model(w[k]);
        end
        ser_frame_n = 1'b1;
        repeat (SETTLE) @(posedge clk);
        push_expect(tag);
        #(4*SER_HALF);
    endtask

    task automatic send1(input logic [15:0] w, input string tag);
        logic [15:0] a [4];
        a = '{w, 16'h0, 16'h0, 16'h0};
        send_frame(a, 1, tag);
    endtask

    // monitor: pops the oldest expectation and compares away from the edge
    initial begin
        forever begin
            @(chk_ev);
            @(negedge clk);
            while (exp_q.size() > 0) begin
                logic [93:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if ({ctl_bits, freq0_word, freq1_word, phase0_word, phase1_word} !== e) begin
                    bad++;
                    $display("FAIL %s: ctl=%h f0=%h f1=%h p0=%h p1=%h expected ctl=%h f0=%h f1=%h p0=%h p1=%h",
                        t, ctl_bits, freq0_word, freq1_word, phase0_word, phase1_word,
                        e[93:80], e[79:52], e[51:24], e[23:12], e[11:0]);
                end
            end
        end
    end

    initial begin
        logic [15:0] fr [4];
        // reset with serial edges so the serial side sees it (R10)
        repeat (3) begin
            #(SER_HALF) ser_clk = 1'b0;
            #(SER_HALF) ser_clk = 1'b1;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        push_expect("R10 reset state");
        #(2*SER_HALF);

        send1(16'h2DEA, "R9 control fields and R3 route");           // paired mode on
        send1(16'h2000, "R9 control reload");
        send1(16'h4000 | 16'h1234, "R5 first half holds register");
        send1(16'h4000 | 16'h0ABC, "R5 pair commits both halves");
        fr = '{16'h8000 | 16'h2222, 16'h8000 | 16'h1111, 16'h0, 16'h0};
        send_frame(fr, 2, "R2 streamed pair in one frame");
        send1(16'h4111, "R5 staged again");
        send1(16'hC555, "R7 phase word cancels and R4 phase0");
        send1(16'h4222, "R7 restart holds register");
        send1(16'h4333, "R7 new pair commits");
        send1(16'hFABC, "R4 phase1 with bit12 set");
        send1(16'h0005, "R9 half mode set");                        // B28=0, high=0
        send1(16'h1000, "R3 control half-high");
        send1(16'h8000 | 16'h3FFF, "R6 upper half write");
        send1(16'h0000, "R3 control half-low");
        send1(16'h8001, "R6 lower half write");
        send1(16'h0DAA, "R9 clear bit keeps registers");
        // aborted frame of 5 ones, then a real word (R8)
        ser_frame_n = 1'b0;
        #(SER_HALF);
        for (int b = 0; b < 5; b++) shift_bit(1'b1);
        ser_frame_n = 1'b1;
        #(4*SER_HALF);
        send1(16'hC0FF, "R8 partial frame discarded");
        send1(16'h2000, "R9 paired mode again");
        send1(16'h8005, "R5 stage f1");
        send1(16'h2000, "R7 control cancels");
        send1(16'h8006, "R7 restart after control");
        send1(16'h8007, "R7 commit after control");
        send1(16'h4001, "R5 stage f0");
        send1(16'h8002, "R7 other frequency cancels");
        send1(16'h8003, "R7 other frequency pair");
        fr = '{16'hC001, 16'hC002, 16'hE003, 16'hC004};
        send_frame(fr, 4, "R11 each streamed word once and R2 order");
        send1(16'h4000 | 16'h2ABC, "R11 latency six cycles and R1 bit order");

        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule